// File: doc/BRIEF.md
# Clock Output Divider Factor Calculator

This block works out the settings for a clock output stage that can only divide. The stage has two pieces: a power-of-two prescaler whose exponent is p, and a linear divider whose register field m holds the divisor minus one. Given a parent rate and a wanted output rate, the calculator picks both factors and reports the output rate they really give.

A caller presents both 32-bit rates and a mode flag, then pulses `start`. In round-only mode the caller gets only the achieved rate and the field outputs keep their values. In program mode the field outputs are updated as well. All integer divisions share one serial restoring divider, so a request takes a fixed number of cycles. `start` and `done` are plain pulses and there is no back-pressure. A `start` that arrives while a request is in progress is dropped. The results stay on the outputs until the next completion.

Top module: `clkout_factor_calc`

## Requirements
- R1: After reset, `done`, `err` and `unreachable` are low, and `achieved_rate`, `m_field` and `p_field` are zero.
- R2: A wanted rate above the parent rate is first lowered to the parent rate. The stage cannot multiply.
- R3: The ratio is the parent rate divided by the clamped rate, truncated. p is the smallest value from 0 to 2 for which ratio >> p is below 32. Otherwise p is 3.
- R4: The linear divisor is ratio / 2^p rounded up. In program mode `m_field` becomes that divisor minus one and `p_field` becomes p (p sits in a 2-bit field, m in a 5-bit field).
- R5: `achieved_rate` equals (parent >> p) divided by the linear divisor in use, truncated.
- R6: In round-only mode (`program_mode` = 0), `achieved_rate` and the flags are updated while `m_field` and `p_field` keep their previous values.
- R7: If the clamped rate is zero (a zero wanted rate or a zero parent rate), `done` rises one clock edge after `start` with `err` = 1, `achieved_rate` = 0 and both fields unchanged. No division runs. Otherwise `err` is 0 with `done`.
- R8: If the rounded-up divisor exceeds 32, the divisor in use is 32, `m_field` becomes 31 in program mode, and `unreachable` is 1. Otherwise `unreachable` is 0.
- R9: `done` is high for exactly one cycle. For a valid request it rises 66 clock edges after the edge that samples `start`, which is two divisions of 33 edges each.
- R10: A `start` pulse that comes while a request is in progress is ignored. The running request finishes with its own operands, and `done` is raised only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request pulse |
| program_mode | input | 1 | 1: update fields, 0: round-only |
| parent_rate | input | 32 | Parent clock rate, unsigned |
| req_rate | input | 32 | Wanted output rate, unsigned |
| done | output | 1 | Single-cycle completion pulse |
| err | output | 1 | Zero-rate error, valid with and after done |
| unreachable | output | 1 | Divisor saturated, valid with and after done |
| achieved_rate | output | 32 | Rate the chosen factors give |
| m_field | output | 5 | Linear divide field (divisor minus one) |
| p_field | output | 2 | Power-of-two prescale exponent |

## Verification
A valid request produces its results 66 clock edges after the edge that samples `start`. A zero-rate request produces its results after a single edge. The bench counts falling edges from the `start` edge until `done` is seen, and checks that count against 66 or against 0. It reads every result on that same falling edge and then confirms that `done` has dropped one edge later. For the dropped-start case, the bench still times the result from the first pulse, and the outputs must carry the first request's values.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RATIO = 2'd1,
    ST_SCALE = 2'd2
  } calc_state_t;
endpackage

// File: rtl/clkout_iter_div.sv
module clkout_iter_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         fin
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [W:0]    shifted;
  logic [W-1:0]  rem_n, quo_n;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    if (shifted >= {1'b0, dsr_q}) begin
      rem_n = W'(shifted - {1'b0, dsr_q});
      quo_n = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_n = shifted[W-1:0];
      quo_n = {quo_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        dsr_q  <= divisor;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          busy_q <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R9
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R9
  fin_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $past(busy_q));
endmodule

// File: rtl/clkout_prescale_sel.sv
module clkout_prescale_sel #(
  parameter int W   = 32,
  parameter int M_W = 5,
  parameter int P_W = 2
) (
  input  logic [W-1:0]   ratio,
  output logic [P_W-1:0] p_sel,
  output logic [W-1:0]   lin_div
);
  localparam int LIMIT = 2 ** M_W;
  localparam int MAXP  = 2 ** P_W - 1;

  logic [W:0] rounded;

  always_comb begin
    p_sel = P_W'(MAXP);
    for (int k = MAXP - 1; k >= 0; k--) begin
      if ((ratio >> k) < W'(LIMIT)) p_sel = P_W'(k);
    end
  end

  always_comb begin
    rounded = ({1'b0, ratio} + (((W + 1)'(1)) << p_sel) - (W + 1)'(1)) >> p_sel;
    lin_div = rounded[W-1:0];
  end
endmodule

// File: rtl/clkout_factor_calc.sv
module clkout_factor_calc
  import clkout_pkg::*;
#(
  parameter int W   = 32,
  parameter int M_W = 5,
  parameter int P_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           program_mode,
  input  logic [W-1:0]   parent_rate,
  input  logic [W-1:0]   req_rate,
  output logic           done,
  output logic           err,
  output logic           unreachable,
  output logic [W-1:0]   achieved_rate,
  output logic [M_W-1:0] m_field,
  output logic [P_W-1:0] p_field
);
  localparam int LIMIT = 2 ** M_W;
  localparam int MAXP  = 2 ** P_W - 1;

  calc_state_t    state_q;
  logic [W-1:0]   parent_q;
  logic           mode_q;
  logic [P_W-1:0] p_hold_q;
  logic [M_W-1:0] m_hold_q;
  logic           sat_hold_q;

  logic [W-1:0]   clamped;
  logic           zero_rate;
  logic           div_go, div_fin;
  logic [W-1:0]   div_a, div_b, div_q;
  logic [P_W-1:0] p_sel;
  logic [W-1:0]   lin_div, div_eff;
  logic           sat;
  logic [M_W-1:0] m_val;

  assign clamped   = (req_rate > parent_rate) ? parent_rate : req_rate;
  assign zero_rate = (clamped == '0);

  clkout_prescale_sel #(.W(W), .M_W(M_W), .P_W(P_W)) u_psel (
    .ratio   (div_q),
    .p_sel   (p_sel),
    .lin_div (lin_div)
  );

  assign sat     = (lin_div > W'(LIMIT));
  assign div_eff = sat ? W'(LIMIT) : lin_div;
  assign m_val   = sat ? '1 : M_W'(lin_div[M_W:0] - (M_W + 1)'(1));

  always_comb begin
    div_go = 1'b0;
    div_a  = parent_q >> p_sel;
    div_b  = div_eff;
    if (state_q == ST_IDLE) begin
      div_go = start && !zero_rate;
      div_a  = parent_rate;
      div_b  = clamped;
    end else if (state_q == ST_RATIO) begin
      div_go = div_fin;
    end
  end

  clkout_iter_div #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .quotient (div_q),
    .fin      (div_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      parent_q      <= '0;
      mode_q        <= 1'b0;
      p_hold_q      <= '0;
      m_hold_q      <= '0;
      sat_hold_q    <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
      unreachable   <= 1'b0;
      achieved_rate <= '0;
      m_field       <= '0;
      p_field       <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (zero_rate) begin
              done          <= 1'b1;
              err           <= 1'b1;
              unreachable   <= 1'b0;
              achieved_rate <= '0;
            end else begin
              parent_q <= parent_rate;
              mode_q   <= program_mode;
              state_q  <= ST_RATIO;
            end
          end
        end
        ST_RATIO: begin
          if (div_fin) begin
            p_hold_q   <= p_sel;
            m_hold_q   <= m_val;
            sat_hold_q <= sat;
            state_q    <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (div_fin) begin
            achieved_rate <= div_q;
            unreachable   <= sat_hold_q;
            err           <= 1'b0;
            done          <= 1'b1;
            if (mode_q) begin
              m_field <= m_hold_q;
              p_field <= p_hold_q;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  round_only_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !mode_q) |-> ($stable(m_field) && $stable(p_field)));

  // R7
  err_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (achieved_rate == '0 && $stable(m_field) && $stable(p_field)));

  // R8
  sat_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unreachable && mode_q) |-> (m_field == '1));

  // R3
  prescale_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RATIO && div_fin) |->
      ((p_sel == P_W'(MAXP) || (div_q >> p_sel) < W'(LIMIT)) &&
       (p_sel == '0 || (div_q >> (p_sel - 1'b1)) >= W'(LIMIT))));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !done) |=> $stable(parent_q) && $stable(mode_q));
endmodule

// File: tb/clkout_factor_calc_bench.sv
`timescale 1ns/1ps
module clkout_factor_calc_bench;
  localparam int NV  = 15;
  localparam int LAT = 2 * (32 + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        program_mode = 1'b0;
  logic [31:0] parent_rate = '0;
  logic [31:0] req_rate = '0;
  logic        done, err, unreachable;
  logic [31:0] achieved_rate;
  logic [4:0]  m_field;
  logic [1:0]  p_field;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  clkout_factor_calc u_clkout_factor_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .program_mode(program_mode),
    .parent_rate(parent_rate), .req_rate(req_rate), .done(done), .err(err),
    .unreachable(unreachable), .achieved_rate(achieved_rate),
    .m_field(m_field), .p_field(p_field));

  localparam logic [31:0] T_PAR [NV] = '{
    32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000, 32'd24000000,
    32'd24000000, 32'd24000000, 32'd255, 32'd256, 32'd257,
    32'd24000000, 32'hFFFFFFFF, 32'd31, 32'd63, 32'd64};
  localparam logic [31:0] T_REQ [NV] = '{
    32'd24000000, 32'd48000000, 32'd1000000, 32'd750000, 32'd700000,
    32'd200000, 32'd100000, 32'd1, 32'd1, 32'd1,
    32'd32768, 32'd1, 32'd1, 32'd1, 32'd1};
  localparam logic [31:0] T_ACH [NV] = '{
    32'd24000000, 32'd24000000, 32'd1000000, 32'd750000, 32'd705882,
    32'd200000, 32'd100000, 32'd0, 32'd1, 32'd1,
    32'd93750, 32'd16777215, 32'd1, 32'd0, 32'd1};
  localparam logic [4:0] T_M [NV] = '{
    5'd0, 5'd0, 5'd23, 5'd15, 5'd16, 5'd29, 5'd29, 5'd31, 5'd31, 5'd31,
    5'd31, 5'd31, 5'd30, 5'd31, 5'd15};
  localparam logic [1:0] T_P [NV] = '{
    2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd3,
    2'd3, 2'd3, 2'd0, 2'd1, 2'd2};
  localparam logic T_SAT [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Pulse start, then count falling edges until done is seen.
  task automatic run_calc(input logic mode, input logic [31:0] par, input logic [31:0] req,
                          input logic extra_start, output int lat);
    @(negedge clk);
    program_mode = mode;
    parent_rate  = par;
    req_rate     = req;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (extra_start && lat == 10) begin
        parent_rate = 32'd5;
        req_rate    = 32'd1;
        start       = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9: done never seen, actual 0 expected 1");
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 unreachable", 32'(unreachable), 0);
    chk("R1 achieved", achieved_rate, 0);
    chk("R1 m", 32'(m_field), 0);
    chk("R1 p", 32'(p_field), 0);
    rst_n = 1'b1;

    // Vector table in program mode: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      run_calc(1'b1, T_PAR[i], T_REQ[i], 1'b0, lat);
      chk("R9 latency", 32'(lat), 32'(LAT));
      chk("R5 achieved", achieved_rate, T_ACH[i]);
      chk("R4 m", 32'(m_field), 32'(T_M[i]));
      chk("R3 p", 32'(p_field), 32'(T_P[i]));
      chk("R8 unreachable", 32'(unreachable), 32'(T_SAT[i]));
      chk("R7 err low", 32'(err), 0);
      @(negedge clk);
      chk("R9 one-cycle done", 32'(done), 0);
    end

    // R6 round-only keeps m=15 p=2 from the last vector
    run_calc(1'b0, 32'd24000000, 32'd200000, 1'b0, lat);
    chk("R6 achieved", achieved_rate, 32'd200000);
    chk("R6 m kept", 32'(m_field), 15);
    chk("R6 p kept", 32'(p_field), 2);

    // R7 zero wanted rate
    run_calc(1'b1, 32'd24000000, 32'd0, 1'b0, lat);
    chk("R7 latency", 32'(lat), 0);
    chk("R7 err", 32'(err), 1);
    chk("R7 achieved", achieved_rate, 0);
    chk("R7 m kept", 32'(m_field), 15);
    chk("R7 p kept", 32'(p_field), 2);
    // R7 zero parent rate
    run_calc(1'b1, 32'd0, 32'd1000, 1'b0, lat);
    chk("R7 zero parent err", 32'(err), 1);
    chk("R7 zero parent latency", 32'(lat), 0);
    @(negedge clk);
    chk("R9 err done one-cycle", 32'(done), 0);

    // R10 start while busy is dropped
    run_calc(1'b1, 32'd24000000, 32'd1000000, 1'b1, lat);
    chk("R10 latency", 32'(lat), 32'(LAT));
    chk("R10 achieved", achieved_rate, 32'd1000000);
    chk("R10 m", 32'(m_field), 23);
    chk("R10 err", 32'(err), 0);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < LAT + 10; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R10 no second done", 32'(lat), 0);

    finish_run();
  end
endmodule